// File: doc/BRIEF.md
# Swept-Duty PWM Generator

This block drives a fixed-frequency pulse-width-modulated output whose duty ratio climbs by itself. A free-running tick counter splits time into periods of 80 clock ticks; with a 40 MHz clock that is a 2 µs period, or 500 kHz. Each period opens with a high phase of `code × 8` ticks and closes with a low phase for the remaining ticks. The duty code is an integer from 0 to 10, one code step per tenth of full scale.

An internal sweep sequencer raises the code by one after every `STEP_PERIODS` completed periods. After code 10 it falls back to 0. The code changes only at the moment the tick counter wraps, so no period is ever shortened or split between two duty settings. The output is set by comparing the counter with the high-tick count, not by flipping a level once per period, so the output frequency equals the period rate.

The output is produced by a three-state phase machine, `PH_OFF`, `PH_HIGH` and `PH_LOW`, whose next state is computed from the next counter and code values, so `pwm_o` comes straight from a flop. Its transitions are:
- `OFF→HIGH` and `OFF→LOW` when enable resumes.
- `HIGH→LOW` when the count reaches the high-tick count.
- `LOW→HIGH` at a wrap with a non-zero code.
- `HIGH→HIGH` across a wrap at code 10.
- `LOW→LOW` across a wrap at code 0.
- any state`→OFF` when enable is sampled low or reset is asserted.

A one-cycle `period_start_o` flag marks each new period so that pulse widths can be measured.

Top module: `swept_pwm_gen`

## Requirements
- R1: The tick counter runs through the values 0 to 79 and then wraps to 0, so consecutive period starts are exactly 80 enabled cycles apart.
- R2: In the cycle where the count is k, `pwm_o` is 1 exactly when k < 8 × duty code. The output is high for the first code × 8 cycles of a period and low for the rest.
- R3: Code 0 holds `pwm_o` at 0 for the whole period, and code 10 holds it at 1 for all 80 cycles, with no low cycle at the period edge.
- R4: At each sweep step the code increases by 1, and after code 10 the next value is 0. After reset the code is 0, and the first step takes it to 1.
- R5: `duty_code_o` changes only in the cycle where the count returns to 0. This is the cycle in which `period_start_o` is 1. The code is constant for the rest of the period.
- R6: The code advances once per `STEP_PERIODS` period wraps, so each code value lasts exactly `STEP_PERIODS` periods.
- R7: A synchronous reset, when asserted, sets the following regardless of enable: count 0, code 0, `pwm_o` 0 and `period_start_o` 0.
- R8: While `en_i` is sampled low, the count and code hold and `pwm_o` and `period_start_o` are 0. When enable returns, the count continues from the held value, so the interrupted period still totals 80 enabled counts.
- R9: `period_start_o` is a single-cycle pulse. It is 1 only in the cycle where the count has just wrapped to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock (40 MHz nominal) |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low freezes the counter and forces the output low |
| pwm_o | output | 1 | Registered PWM output |
| duty_code_o | output | 4 | Current duty code, 0 to 10 (tenths of full scale) |
| period_start_o | output | 1 | One-cycle flag in the first cycle of each period |

## Verification
The bench follows every cycle of two full sweeps and predicts the level of each tick from its position in the period. This catches a design that toggles once per period and runs at half frequency, one that is off by one at the high/low edge, and one that lets code 10 dip low for a cycle at the wrap. It checks the wrap from 10 back to 0 and the first step after reset, which catch a sequencer that saturates, overshoots to 11, or starts from the wrong value. A second instance with three periods per step shows whether the divider counts wraps rather than cycles. Enable is dropped partway through a high phase: a design that restarts the period, lets the counter drift while frozen, or leaves the output high would show the wrong number of cycles to the next period start.

// File: rtl/swpwm_pkg.sv
package swpwm_pkg;

    // Phase of the output within the current period.
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/swpwm_tick_ctr.sv
module swpwm_tick_ctr #(
    parameter int PERIOD_TICKS = 80,
    localparam int CNT_W       = $clog2(PERIOD_TICKS)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Next count: hold when disabled, wrap after the last tick.
    always_comb begin
        wrap_o = en_i && (cnt_q == CNT_LAST);
        if (!en_i) begin
            cnt_d_o = cnt_q;
        end else if (wrap_o) begin
            cnt_d_o = '0;
        end else begin
            cnt_d_o = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d_o;
        end
    end

    assign cnt_q_o = cnt_q;

    // R1: the counter never leaves the period range
    a_r1_count_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < CNT_W'(PERIOD_TICKS));

    // R1: the last tick is followed by tick zero
    a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && cnt_q == CNT_LAST) |=> (cnt_q == '0));

    // R8: a disabled cycle leaves the count unchanged
    a_r8_count_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/swpwm_duty_seq.sv
module swpwm_duty_seq #(
    parameter int DUTY_STEPS   = 10,
    parameter int STEP_PERIODS = 1,
    localparam int CODE_W      = $clog2(DUTY_STEPS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wrap_i,
    output logic [CODE_W-1:0] code_q_o,
    output logic [CODE_W-1:0] code_d_o
);

    localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(DUTY_STEPS);
    localparam int PER_W = (STEP_PERIODS > 1) ? $clog2(STEP_PERIODS) : 1;

    logic [CODE_W-1:0] code_q;
    logic              step;

    // Period divider, present only when more than one period per step.
    generate
        if (STEP_PERIODS > 1) begin : g_div
            logic [PER_W-1:0] per_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    per_q <= '0;
                end else if (wrap_i) begin
                    if (per_q == PER_W'(STEP_PERIODS - 1)) begin
                        per_q <= '0;
                    end else begin
                        per_q <= per_q + PER_W'(1);
                    end
                end
            end
            assign step = wrap_i && (per_q == PER_W'(STEP_PERIODS - 1));

            // R6: the divider stays below its limit
            a_r6_div_range: assert property (@(posedge clk_i) disable iff (rst_i)
                per_q < PER_W'(STEP_PERIODS));
        end else begin : g_nodiv
            assign step = wrap_i;
        end
    endgenerate

    // Next code: step in tenths, fall back to zero after full scale.
    always_comb begin
        if (!step) begin
            code_d_o = code_q;
        end else if (code_q == CODE_MAX) begin
            code_d_o = '0;
        end else begin
            code_d_o = code_q + CODE_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            code_q <= '0;
        end else begin
            code_q <= code_d_o;
        end
    end

    assign code_q_o = code_q;

    // R4: the code never exceeds full scale
    a_r4_code_range: assert property (@(posedge clk_i) disable iff (rst_i)
        code_q <= CODE_MAX);

    // R4: stepping from full scale lands on zero
    a_r4_full_wraps: assert property (@(posedge clk_i) disable iff (rst_i)
        (wrap_i && code_q == CODE_MAX && step) |=> (code_q == '0));

    // R5: without a period wrap the code holds
    a_r5_code_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_i |=> $stable(code_q));

endmodule

// File: rtl/swpwm_phase_fsm.sv
module swpwm_phase_fsm
    import swpwm_pkg::*;
#(
    parameter int PERIOD_TICKS = 80,
    parameter int DUTY_STEPS   = 10,
    localparam int CNT_W       = $clog2(PERIOD_TICKS),
    localparam int CODE_W      = $clog2(DUTY_STEPS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  cnt_d_i,
    input  logic [CODE_W-1:0] code_d_i,
    output logic              pwm_o,
    output logic              period_start_o
);

    localparam int TICK_STEP = PERIOD_TICKS / DUTY_STEPS;
    localparam int HI_W      = CNT_W + 1;

    phase_e          state_q;
    phase_e          state_d;
    logic [HI_W-1:0] hi_ticks_d;
    logic            start_q;

    // Next phase is taken from the count and code the next cycle will hold.
    always_comb begin
        hi_ticks_d = HI_W'(code_d_i) * HI_W'(TICK_STEP);
        if (!en_i) begin
            state_d = PH_OFF;
        end else if (HI_W'(cnt_d_i) < hi_ticks_d) begin
            state_d = PH_HIGH;
        end else begin
            state_d = PH_LOW;
        end
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PH_OFF;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= en_i && (cnt_d_i == '0);
        end
    end

    // Outputs from state.
    always_comb begin
        pwm_o = 1'b0;
        unique case (state_q)
            PH_HIGH: pwm_o = 1'b1;
            PH_LOW:  pwm_o = 1'b0;
            PH_OFF:  pwm_o = 1'b0;
            default: pwm_o = 1'b0;
        endcase
    end

    assign period_start_o = start_q;

    // R8: a disabled cycle turns the output and the start flag off
    a_r8_off_when_disabled: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!pwm_o && !period_start_o));

    // R9: the start flag never lasts two cycles
    a_r9_start_single: assert property (@(posedge clk_i) disable iff (rst_i)
        period_start_o |=> !period_start_o);

endmodule

// File: rtl/swept_pwm_gen.sv
module swept_pwm_gen #(
    parameter int PERIOD_TICKS = 80,
    parameter int DUTY_STEPS   = 10,
    parameter int STEP_PERIODS = 1,
    localparam int CNT_W       = $clog2(PERIOD_TICKS),
    localparam int CODE_W      = $clog2(DUTY_STEPS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    output logic              pwm_o,
    output logic [CODE_W-1:0] duty_code_o,
    output logic              period_start_o
);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    logic              wrap;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;

    swpwm_tick_ctr #(
        .PERIOD_TICKS (PERIOD_TICKS)
    ) u_tick_ctr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_d),
        .wrap_o  (wrap)
    );

    swpwm_duty_seq #(
        .DUTY_STEPS   (DUTY_STEPS),
        .STEP_PERIODS (STEP_PERIODS)
    ) u_duty_seq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wrap_i   (wrap),
        .code_q_o (code_q),
        .code_d_o (code_d)
    );

    swpwm_phase_fsm #(
        .PERIOD_TICKS (PERIOD_TICKS),
        .DUTY_STEPS   (DUTY_STEPS)
    ) u_phase_fsm (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .en_i           (en_i),
        .cnt_d_i        (cnt_d),
        .code_d_i       (code_d),
        .pwm_o          (pwm_o),
        .period_start_o (period_start_o)
    );

    assign duty_code_o = code_q;

    // R9: the start flag coincides with count zero
    a_r9_start_at_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        period_start_o |-> (cnt_q == '0));

    // R3: a high output never appears under code zero
    a_r3_low_at_code_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        pwm_o |-> (code_q != '0));

    // R3: at full scale with enable steady the output stays high
    a_r3_full_stays_high: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwm_o && en_i && code_d == CODE_W'(DUTY_STEPS)) |=> pwm_o);

endmodule

// File: tb/test_swept_pwm_gen.sv
module test_swept_pwm_gen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;

    always #10 clk = ~clk;

    logic       pwm_a, ps_a, pwm_b, ps_b;
    logic [3:0] dc_a, dc_b;

    swept_pwm_gen i_swept_pwm_gen (
        .clk_i (clk), .rst_i (rst), .en_i (en),
        .pwm_o (pwm_a), .duty_code_o (dc_a), .period_start_o (ps_a)
    );

    swept_pwm_gen #(.STEP_PERIODS(3)) i_swept_pwm_gen_slow (
        .clk_i (clk), .rst_i (rst), .en_i (en),
        .pwm_o (pwm_b), .duty_code_o (dc_b), .period_start_o (ps_b)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int next_code(input int c);
        return (c == 10) ? 0 : c + 1;
    endfunction

    // Cycle-by-cycle monitor
    bit mon_on = 1'b0;
    bit a_have = 1'b0, a_first = 1'b1, seen_full = 1'b0, seen_wrap = 1'b0;
    int a_pos = 0, a_code = 0;
    bit b_have = 1'b0, b_seen_change = 1'b0;
    int b_code = 0, b_run = 0, b_changes = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (ps_a) begin
                if (a_first) begin
                    check(dc_a == 4'd1, "R4 first step after reset", dc_a, 1);
                    a_first = 1'b0;
                end
                if (a_have) begin
                    check(a_pos == 80, "R1 R9 period length", a_pos, 80);
                    check(int'(dc_a) == next_code(a_code), "R4 code step", dc_a, next_code(a_code));
                    if (a_code == 10 && dc_a == 4'd0) seen_wrap = 1'b1;
                end
                a_have = 1'b1;
                a_pos  = 0;
                a_code = int'(dc_a);
            end
            if (a_have) begin
                if (a_code == 0 || a_code == 10)
                    check(pwm_a == (a_pos < a_code * 8), "R3 constant level", pwm_a, a_pos < a_code * 8);
                else
                    check(pwm_a == (a_pos < a_code * 8), "R2 high/low split", pwm_a, a_pos < a_code * 8);
                check(int'(dc_a) == a_code, "R5 code steady within period", dc_a, a_code);
                if (a_code == 10) seen_full = 1'b1;
                a_pos++;
            end
            if (ps_b) begin
                if (b_have && int'(dc_b) != b_code) begin
                    check(int'(dc_b) == next_code(b_code), "R6 slow code step", dc_b, next_code(b_code));
                    if (b_seen_change) check(b_run == 3, "R6 periods per code", b_run, 3);
                    b_seen_change = 1'b1;
                    b_changes++;
                    b_run = 1;
                end else begin
                    b_run++;
                end
                b_have = 1'b1;
                b_code = int'(dc_b);
            end
        end
    end

    initial begin
        // R7: reset dominates enable
        rst = 1'b1;
        en  = 1'b1;
        repeat (5) @(negedge clk);
        check(pwm_a == 1'b0, "R7 reset output", pwm_a, 0);
        check(dc_a == 4'd0, "R7 reset code", dc_a, 0);
        check(ps_a == 1'b0, "R7 reset start flag", ps_a, 0);
        check(dc_b == 4'd0, "R7 reset code slow", dc_b, 0);

        rst    = 1'b0;
        mon_on = 1'b1;
        repeat (40 * 80 + 20) @(negedge clk);
        check(seen_full, "R3 full-scale period observed", seen_full, 1);
        check(seen_wrap, "R4 wrap from 10 to 0 observed", seen_wrap, 1);
        check(b_changes >= 10, "R6 slow sweep progressed", b_changes, 10);

        // R8: drop enable inside a high phase
        mon_on = 1'b0;
        begin
            int code_held;
            int n;
            do @(negedge clk); while (!(ps_a && dc_a >= 4'd1));
            code_held = int'(dc_a);
            repeat (3) @(negedge clk);
            en = 1'b0;
            @(negedge clk);
            check(pwm_a == 1'b0, "R8 output low when disabled", pwm_a, 0);
            for (int i = 0; i < 20; i++) begin
                check(pwm_a == 1'b0 && ps_a == 1'b0, "R8 idle outputs", pwm_a, 0);
                check(int'(dc_a) == code_held, "R8 code held", dc_a, code_held);
                @(negedge clk);
            end
            en = 1'b1;
            n  = 0;
            do begin
                @(negedge clk);
                n++;
                if (n == 1)
                    check(pwm_a == (4 < code_held * 8), "R8 resume level", pwm_a, 4 < code_held * 8);
            end while (!ps_a && n < 200);
            check(n == 77, "R8 resumed period length", n, 77);
        end

        a_have = 1'b0;
        b_have = 1'b0;
        b_seen_change = 1'b0;
        mon_on = 1'b1;
        repeat (12 * 80) @(negedge clk);
        mon_on = 1'b0;

        // R7: reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        check(pwm_a == 1'b0 && ps_a == 1'b0, "R7 mid-run reset outputs", pwm_a, 0);
        check(dc_a == 4'd0 && dc_b == 4'd0, "R7 mid-run reset code", dc_a, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule